// File: doc/BRIEF.md
# Multi-Channel Gated Clock Divider

A bank of clock outputs that all derive from one parent clock. Each output has its own divider: the high phase and the low phase of the output are counted separately in parent cycles, so any duty cycle up to the field width is possible. A divide-enable bit per channel chooses between dividing and passing the parent clock straight through. Each gatable channel has a gate bit that holds its output low when cleared. Channels built without a gate run permanently.

Software owns all rate arithmetic. It works out the high count H and the low count L and writes them to the channel's divider register through a small write/read register port. A change of fields, or a change of the enable, takes effect only when the current output period ends. A change of the gate takes effect only while the pre-gate clock is low. Neither change can cut a high pulse short.

Each channel runs a three-state machine. The states are PASS (bypass), HIGH and LOW. The transitions are:
- PASS to HIGH ("arm"), when the enable bit is seen set; the fields are latched at this point.
- HIGH to HIGH ("count high") and HIGH to LOW ("fall"), after H+1 cycles in HIGH.
- LOW to LOW ("count low").
- LOW to HIGH ("reload"), at the end of the period with the enable still set; new fields are latched at this point.
- LOW to PASS ("release"), at the end of the period with the enable clear.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset every channel is in bypass with all counters zero. Every gatable channel (0, 1, 2) holds its output low, and the ungated channel 3 follows the parent clock. All register reads return zero.
- R2: While a channel's divide-enable bit is clear and its gate is on, its output equals the parent clock: high during the parent's high half and low during its low half.
- R3: With the divider enabled, the output stays high for exactly H+1 parent cycles and then low for exactly L+1 parent cycles, repeating. H is the high-count field and L is the low-count field.
- R4: The field layout is fixed per channel by parameters, and bits outside a channel's fields are ignored. The default layout is:
  - channel 0: enable at bit 31, H in [15:8], L in [7:0];
  - channel 1: enable at bit 31, H in [11:8], L in [3:0];
  - channel 2: enable at bit 16, H in [7:4], L in [3:0];
  - channel 3: enable at bit 31, H in [10:8], L in [2:0].
- R5: H=0 and L=0 with the divider enabled divide the parent by two at 50% duty.
- R6: Each gatable channel n (n = 0, 1, 2) is gated by bit n of its own gate register. When that bit is clear the output is held low, whatever the other bits hold.
- R7: Channel 3 has no gate. It is always on, writes to its gate address change nothing, and that address reads as zero.
- R8: New H and L values written during a period are used only from the next period onward. The period in progress completes with its old lengths.
- R9: A gate change never truncates a high pulse. Gating off during a high phase lets that phase finish. After gating on, the first visible high pulse has its full H+1 length.
- R10: Clearing the enable during division finishes the current period first, and the channel then returns to bypass.
- R11: Address bit 2 selects the register space: 0 for divider registers, 1 for gate registers. Address bits [1:0] give the channel. Reads are combinational and return every bit last written, including bits the channel does not use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address (space bit and channel) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr |
| clk_out | output | 4 | Channel clock outputs |

## Verification
Two things can fall on the same parent edge: a register write, and the period boundary where a channel latches its fields or samples its gate. The bench provokes this in three ways:
- it writes new fields and disables the divider in the middle of a high phase;
- it sweeps a gate-on write across eight phase offsets of an eight-cycle period;
- it writes a gate-off during a high phase.

Each case is judged by counting consecutive high and low samples. The run in progress must keep its old length, and the following run must have the new one. The bench expects no short pulse at any boundary.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    // Per-channel divider phase
    typedef enum logic [1:0] {
        DV_PASS = 2'd0,
        DV_HIGH = 2'd1,
        DV_LOW  = 2'd2
    } dv_state_e;
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs #(
    parameter int       NCH = 4,
    parameter int       DW  = 32,
    parameter int       CW  = 8,
    parameter int       AW  = 3,
    parameter logic [NCH-1:0] GATE_MASK = '1,
    parameter int       EN_POS   [NCH] = '{31, 31, 16, 31},
    parameter int       HI_LSB   [NCH] = '{8, 8, 4, 8},
    parameter int       HI_W     [NCH] = '{8, 4, 4, 3},
    parameter int       LO_LSB   [NCH] = '{0, 0, 0, 0},
    parameter int       LO_W     [NCH] = '{8, 4, 4, 3},
    parameter int       GATE_POS [NCH] = '{0, 1, 2, 0}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           wr_data,
    output logic [DW-1:0]           rd_data,
    output logic [NCH-1:0]          en_b,
    output logic [NCH-1:0][CW-1:0]  hi_f,
    output logic [NCH-1:0][CW-1:0]  lo_f,
    output logic [NCH-1:0]          g_req
);
    localparam int CHW = AW - 1;

    logic                   sp_gate;
    logic [CHW-1:0]         ch_sel;
    logic [NCH-1:0][DW-1:0] div_v;
    logic [NCH-1:0][DW-1:0] gate_v;

    assign sp_gate = addr[AW-1];
    assign ch_sel  = addr[CHW-1:0];

    for (genvar i = 0; i < NCH; i++) begin : g_reg
        logic [DW-1:0] div_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                div_q <= '0;
            else if (wr_en && !sp_gate && ch_sel == CHW'(i))
                div_q <= wr_data;
        end

        assign div_v[i] = div_q;
        assign en_b[i]  = div_q[EN_POS[i]];
        assign hi_f[i]  = CW'(div_q[HI_LSB[i] +: HI_W[i]]);
        assign lo_f[i]  = CW'(div_q[LO_LSB[i] +: LO_W[i]]);

        if (GATE_MASK[i]) begin : g_gated
            logic [DW-1:0] gate_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    gate_q <= '0;
                else if (wr_en && sp_gate && ch_sel == CHW'(i))
                    gate_q <= wr_data;
            end
            assign gate_v[i] = gate_q;
            assign g_req[i]  = gate_q[GATE_POS[i]];
        end else begin : g_open
            assign gate_v[i] = '0;
            assign g_req[i]  = 1'b1;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCH; i++) begin
            if (ch_sel == CHW'(i))
                rd_data = sp_gate ? gate_v[i] : div_v[i];
        end
    end
endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan
    import clkdiv_pkg::*;
#(
    parameter int CW       = 8,
    parameter bit GATE_RST = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] hi_fld,
    input  logic [CW-1:0] lo_fld,
    input  logic          gate_req,
    output logic          clk_o,
    output logic          ph_high,
    output logic          in_pass,
    output logic          gate_on
);
    dv_state_e     st, st_n;
    logic [CW-1:0] cnt, cnt_n;
    logic [CW-1:0] h_q, h_n, l_q, l_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= DV_PASS;
            cnt <= '0;
            h_q <= '0;
            l_q <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            h_q <= h_n;
            l_q <= l_n;
        end
    end

    // Next state: arm, count high, fall, count low, reload, release
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        h_n   = h_q;
        l_n   = l_q;
        unique case (st)
            DV_PASS: begin
                if (en) begin
                    st_n  = DV_HIGH;
                    cnt_n = '0;
                    h_n   = hi_fld;
                    l_n   = lo_fld;
                end
            end
            DV_HIGH: begin
                if (cnt == h_q) begin
                    st_n  = DV_LOW;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            DV_LOW: begin
                if (cnt == l_q) begin
                    cnt_n = '0;
                    if (en) begin
                        st_n = DV_HIGH;
                        h_n  = hi_fld;
                        l_n  = lo_fld;
                    end else begin
                        st_n = DV_PASS;
                    end
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            default: st_n = DV_PASS;
        endcase
    end

    // Outputs
    always_comb begin
        ph_high = (st == DV_HIGH);
        in_pass = (st == DV_PASS);
        clk_o   = ((st == DV_PASS) ? clk : (st == DV_HIGH)) & gate_on;
    end

    // Gate follows its request only while the pre-gate clock is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)
            gate_on <= GATE_RST;
        else if (st != DV_HIGH)
            gate_on <= gate_req;
    end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
    parameter int       NCH = 4,
    parameter int       DW  = 32,
    parameter int       CW  = 8,
    parameter logic [NCH-1:0] GATE_MASK = 4'b0111,
    parameter int       EN_POS   [NCH] = '{31, 31, 16, 31},
    parameter int       HI_LSB   [NCH] = '{8, 8, 4, 8},
    parameter int       HI_W     [NCH] = '{8, 4, 4, 3},
    parameter int       LO_LSB   [NCH] = '{0, 0, 0, 0},
    parameter int       LO_W     [NCH] = '{8, 4, 4, 3},
    parameter int       GATE_POS [NCH] = '{0, 1, 2, 0},
    localparam int      AW = 1 + ((NCH > 1) ? $clog2(NCH) : 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wr_data,
    output logic [DW-1:0]  rd_data,
    output logic [NCH-1:0] clk_out
);
    logic [NCH-1:0]         en_b;
    logic [NCH-1:0][CW-1:0] hi_f;
    logic [NCH-1:0][CW-1:0] lo_f;
    logic [NCH-1:0]         g_req;
    logic [NCH-1:0]         ph_high;
    logic [NCH-1:0]         in_pass;
    logic [NCH-1:0]         gate_on;

    clkdiv_regs #(
        .NCH(NCH), .DW(DW), .CW(CW), .AW(AW), .GATE_MASK(GATE_MASK),
        .EN_POS(EN_POS), .HI_LSB(HI_LSB), .HI_W(HI_W),
        .LO_LSB(LO_LSB), .LO_W(LO_W), .GATE_POS(GATE_POS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data),
        .en_b(en_b), .hi_f(hi_f), .lo_f(lo_f), .g_req(g_req)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        clkdiv_chan #(
            .CW(CW), .GATE_RST(!GATE_MASK[i])
        ) u_ch (
            .clk(clk), .rst_n(rst_n), .en(en_b[i]),
            .hi_fld(hi_f[i]), .lo_fld(lo_f[i]), .gate_req(g_req[i]),
            .clk_o(clk_out[i]), .ph_high(ph_high[i]),
            .in_pass(in_pass[i]), .gate_on(gate_on[i])
        );
    end
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
    parameter int NCH = 4,
    parameter int DW  = 32,
    parameter int AW  = 3,
    parameter logic [NCH-1:0] GATE_MASK = '1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic [AW-1:0]  addr,
    input logic [DW-1:0]  wr_data,
    input logic [DW-1:0]  rd_data,
    input logic [NCH-1:0] clk_out,
    input logic [NCH-1:0] ph_high,
    input logic [NCH-1:0] in_pass,
    input logic [NCH-1:0] gate_on
);
    localparam int CHW = AW - 1;

    // R1: first cycle out of reset finds every channel in bypass
    p_reset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (&in_pass));

    // R11: a divider write reads back in full on the next cycle
    p_readback_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && !$past(addr[AW-1]) && addr == $past(addr)
         && int'($past(addr[CHW-1:0])) < NCH) |-> rd_data == $past(wr_data));

    // R7: gate address of an ungated channel reads zero
    p_open_gate_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[AW-1] && int'(addr[CHW-1:0]) < NCH && !GATE_MASK[addr[CHW-1:0]])
        |-> rd_data == '0);

    for (genvar i = 0; i < NCH; i++) begin : g_prop
        // R9: gate state never moves across a high phase
        p_gate_still_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ph_high[i] |-> $stable(gate_on[i]));

        // R6: a closed gate keeps the output low
        p_gate_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !gate_on[i] |-> !clk_out[i]);

        // R10: bypass is entered only from a low phase
        p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(in_pass[i]) |-> !$past(ph_high[i]));

        // R8: a high phase always ends into a low phase
        p_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ph_high[i]) |-> !in_pass[i]);
    end
endmodule

bind clkdiv_bank clkdiv_bank_chk #(
    .NCH(NCH), .DW(DW), .AW(AW), .GATE_MASK(GATE_MASK)
) u_chk (.*);

// File: tb/test_clkdiv_bank.sv
`timescale 1ns/1ps
module test_clkdiv_bank;
    localparam int NCH = 4;
    localparam int DW  = 32;
    localparam int AW  = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [AW-1:0]  addr = '0;
    logic [DW-1:0]  wr_data = '0;
    wire  [DW-1:0]  rd_data;
    wire  [NCH-1:0] clk_out;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    clkdiv_bank i_clkdiv_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .clk_out(clk_out)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one parent cycle; samples sit 5 ns after the rising edge
    task automatic tick();
        @(posedge clk);
        #5;
        wr_en = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        tick();
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic logic [AW-1:0] dadr(input int ch);
        return {1'b0, 2'(ch)};
    endfunction

    function automatic logic [AW-1:0] gadr(input int ch);
        return {1'b1, 2'(ch)};
    endfunction

    // checks the output in both halves of the next parent cycle
    task automatic pass_chk(input int ch, input logic exp_hi, input string req);
        logic a, b;
        @(posedge clk);
        #5; a = clk_out[ch];
        #10; b = clk_out[ch];
        chk(req, a, exp_hi);
        chk(req, b, 1'b0);
    endtask

    task automatic wait_rise(input int ch, input string req);
        logic prev;
        bit   hit;
        prev = clk_out[ch];
        hit  = 1'b0;
        for (int k = 0; k < 2000 && !hit; k++) begin
            tick();
            if (!prev && clk_out[ch]) hit = 1'b1;
            prev = clk_out[ch];
        end
        if (!hit) chk({req, " no rising edge"}, 0, 1);
    endtask

    // current sample already at lvl; counts it and the ones that follow
    task automatic run_len(input int ch, input logic lvl, output int n);
        bit stop;
        n = 1;
        stop = 1'b0;
        for (int k = 0; k < 700 && !stop; k++) begin
            tick();
            if (clk_out[ch] != lvl) stop = 1'b1;
            else n++;
        end
    endtask

    task automatic measure(input int ch, input int eh, input int el, input string req);
        int nh, nl;
        wait_rise(ch, req);
        run_len(ch, 1'b1, nh);
        run_len(ch, 1'b0, nl);
        chk({req, " high length"}, nh, eh + 1);
        chk({req, " low length"},  nl, el + 1);
    endtask

    initial begin
        logic [DW-1:0] d;
        int n;

        repeat (3) @(negedge clk);
        #3 rst_n = 1'b1;
        tick();

        // R1: reset state
        for (int c = 0; c < 3; c++) pass_chk(c, 1'b0, "R1 gated off");
        pass_chk(3, 1'b1, "R1 ungated follows parent");
        for (int c = 0; c < NCH; c++) begin
            rd(dadr(c), d); chk("R1 divider read", d, 0);
            rd(gadr(c), d); chk("R1 gate read", d, 0);
        end

        // R6: only the channel's own gate bit counts
        wr(gadr(1), 32'hFFFF_FFFD);
        pass_chk(1, 1'b0, "R6 wrong bit keeps gate closed");
        rd(gadr(1), d); chk("R11 gate readback", d, 32'hFFFF_FFFD);
        wr(gadr(0), 32'h0000_0001);
        wr(gadr(1), 32'h0000_0002);
        wr(gadr(2), 32'h0000_0004);
        // R2: bypass with gate on
        for (int c = 0; c < 3; c++) pass_chk(c, 1'b1, "R2 bypass");

        // R11 / R4: full readback, enable at bit 16 for channel 2
        wr(dadr(2), 32'hA5A5_F00F);
        rd(dadr(2), d); chk("R11 divider readback", d, 32'hA5A5_F00F);
        measure(2, 0, 15, "R4 channel 2 layout");

        // R3: sweep of channel 1, junk in unused bits (R4)
        for (int h = 0; h < 4; h++) begin
            for (int l = 0; l < 4; l++) begin
                wr(dadr(1), 32'h8055_0000 | (32'(h) << 8) | 32'(l));
                measure(1, h, l, "R3 sweep");
            end
        end
        wr(dadr(1), 32'h8000_0F0F);
        measure(1, 15, 15, "R3 maximum fields");

        // R5: divide by two on channel 0, then a long high phase
        wr(dadr(0), 32'h8000_0000);
        measure(0, 0, 0, "R5 divide by two");
        wr(dadr(0), 32'h8000_FF01);
        measure(0, 255, 1, "R3 wide high field");

        // R4: channel 3 fields are three bits wide
        wr(dadr(3), 32'h8000_0F0A);
        measure(3, 7, 2, "R4 channel 3 truncation");

        // R7: gate writes do not touch channel 3
        wr(gadr(3), 32'h0000_0000);
        measure(3, 7, 2, "R7 gate write ignored");
        wr(gadr(3), 32'hFFFF_FFFF);
        rd(gadr(3), d); chk("R7 gate read zero", d, 0);

        // R8: reprogram during a high phase
        wr(dadr(1), 32'h8000_0303);
        measure(1, 3, 3, "R8 setup");
        wait_rise(1, "R8");
        tick();
        wr(dadr(1), 32'h8000_0000);
        run_len(1, 1'b1, n); chk("R8 old high kept", n + 2, 4);
        run_len(1, 1'b0, n); chk("R8 old low kept", n, 4);
        run_len(1, 1'b1, n); chk("R8 new high used", n, 1);
        run_len(1, 1'b0, n); chk("R8 new low used", n, 1);

        // R9: gate off in a high phase
        wr(dadr(1), 32'h8000_0303);
        measure(1, 3, 3, "R9 setup");
        wait_rise(1, "R9");
        tick();
        wr(gadr(1), 32'h0);
        run_len(1, 1'b1, n); chk("R9 high not truncated", n + 2, 4);
        n = 0;
        for (int k = 0; k < 20; k++) begin
            tick();
            if (clk_out[1]) n++;
        end
        chk("R9 gated off stays low", n, 0);
        // R9: gate on at each offset within the period
        for (int off = 0; off < 8; off++) begin
            wr(gadr(1), 32'h0);
            repeat (off + 9) tick();
            wr(gadr(1), 32'h2);
            wait_rise(1, "R9 gate on");
            run_len(1, 1'b1, n);
            chk("R9 first high full", n, 4);
        end

        // R10: disable during a high phase
        wr(dadr(1), 32'h8000_0102);
        measure(1, 1, 2, "R10 setup");
        wait_rise(1, "R10");
        wr(dadr(1), 32'h0000_0102);
        run_len(1, 1'b1, n); chk("R10 high finishes", n + 1, 2);
        run_len(1, 1'b0, n); chk("R10 low finishes", n, 3);
        repeat (3) pass_chk(1, 1'b1, "R10 back to bypass");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #4000000;
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule